// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Controller

This block holds a two-bit pending/queued (PQ) state for each of `NUM_SRC` interrupt sources. A source becomes active in one of two ways: a rising edge on its input pin, or a store to its trigger page. The first activation moves an idle source to pending and sends one notification to a downstream router. Further activations while the source is pending only mark it queued. As a result each source has at most one notification outstanding. Software manages the state with loads to fixed offsets inside a source's management page. The offset selects the operation: read the state, force it to one of the four codes, or end the interrupt (EOI). Every such load returns the state as it was before the operation.

Each source gets a window of `2^SHIFT` bytes, and source `s` starts at `s << SHIFT`. When `SHIFT` is 13 or 17, the window is split in two. The lower half is the trigger page and the upper half is the management page. For any other `SHIFT`, the whole window is the management page. The `LEVEL_MASK` parameter marks sources as level-sensitive; a level-sensitive source also reports whether its input is asserted. Notifications leave through a valid/ready port that carries the source number.

Top module: `pq_src_ctrl`

## Requirements
- R1: After reset every source is in state 00 (idle), `ntf_valid` is low and `rsp_valid` is low.
- R2: A trigger on a source in state 00 moves it to 10 (pending) and raises a notification carrying that source number.
- R3: While `ntf_valid` is high and `ntf_ready` is low, `ntf_valid` and `ntf_src` hold. A notification is consumed in the cycle where both are high.
- R4: A trigger on a pending source (10 or 11) moves it to 11 (queued) and sends no notification. A trigger on a source in state 01 (off) has no effect.
- R5: A load at management offset 0x000 is an EOI. If Q was set, or if a level-sensitive input is still asserted, the source returns to 10 with a new notification. Otherwise it returns to 00.
- R6: A load at management offset 0x800 returns the state without changing it. Load data is {5'b0, asserted, P, Q}, and the asserted bit is always 0 for edge sources.
- R7: Loads at management offsets 0xC00, 0xD00, 0xE00 and 0xF00 force PQ to 00, 01, 10 and 11 and send no notification.
- R8: A store at management offset 0x400 performs an EOI when `STORE_EOI_EN` is 1. A store produces no load response.
- R9: Source `s` occupies the bytes starting at `s << SHIFT`. In two-page mode (SHIFT 13 or 17), bit SHIFT-1 set selects the management page, and any store to the trigger page (that bit clear) is a trigger.
- R10: On an edge source, a rising input is a trigger. An input that stays high does not trigger again.
- R11: On a level source, the asserted bit follows the input one cycle late, and a rising input is a trigger.
- R12: A load at any other offset, or to the trigger page, returns 0xFF. Such a load, and a store at any undefined offset, leaves all state unchanged.
- R13: Every load is answered by `rsp_valid` in the next cycle, and the data is the state from before that load.
- R14: When several notifications are waiting, the port offers the lowest-numbered one. The offer stays fixed until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Per-source interrupt inputs |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address in the source region |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 8 | Previous state or 0xFF |
| ntf_valid | output | 1 | Notification offered |
| ntf_src | output | IDX_W | Source number of the notification |
| ntf_ready | input | 1 | Router accepts the notification |

## Verification
Directed sequences walk one source through every PQ code. Each code is hit by store triggers, pin edges, loaded EOIs, stored EOIs and forced states, and these show whether triggers coalesce or are dropped at each state. A level source is EOI'd once with its input still high and once with it low, which separates a re-trigger caused by the level from one caused by Q. Two sources are then raised together with the router stalled, and a lower-numbered source is added while the offer is held; this shows whether the lowest index is chosen and whether the offer stays locked. A long random mix of all operations, pin toggles and ready stalls follows, compared against a model of the rules.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_GET,
    OP_EOI,
    OP_SET00,
    OP_SET01,
    OP_SET10,
    OP_SET11
  } pq_op_e;

  localparam logic [1:0] PQ_IDLE   = 2'b00;
  localparam logic [1:0] PQ_OFF    = 2'b01;
  localparam logic [1:0] PQ_PEND   = 2'b10;
  localparam logic [1:0] PQ_QUEUED = 2'b11;

  localparam logic [11:0] OFF_LD_EOI = 12'h000;
  localparam logic [11:0] OFF_ST_EOI = 12'h400;
  localparam logic [11:0] OFF_GET    = 12'h800;
  localparam logic [11:0] OFF_SET00  = 12'hC00;
  localparam logic [11:0] OFF_SET01  = 12'hD00;
  localparam logic [11:0] OFF_SET10  = 12'hE00;
  localparam logic [11:0] OFF_SET11  = 12'hF00;

  typedef struct packed {
    logic [1:0] pq;
    logic       notify;
  } pq_step_t;

  // Bus operation first, then any trigger seen in the same cycle.
  function automatic pq_step_t pq_step(logic [1:0] cur, pq_op_e op,
                                       logic lvl_hold, logic trig);
    pq_step_t r;
    r.pq     = cur;
    r.notify = 1'b0;
    case (op)
      OP_EOI: begin
        if (cur[0] || lvl_hold) begin
          r.pq     = PQ_PEND;
          r.notify = 1'b1;
        end else begin
          r.pq = PQ_IDLE;
        end
      end
      OP_SET00: r.pq = PQ_IDLE;
      OP_SET01: r.pq = PQ_OFF;
      OP_SET10: r.pq = PQ_PEND;
      OP_SET11: r.pq = PQ_QUEUED;
      default:  r.pq = cur;
    endcase
    if (trig) begin
      if (r.pq == PQ_IDLE) begin
        r.pq     = PQ_PEND;
        r.notify = 1'b1;
      end else if (r.pq == PQ_PEND) begin
        r.pq = PQ_QUEUED;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/pq_addr_decode.sv
module pq_addr_decode
  import pq_src_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int SHIFT        = 13,
  parameter bit STORE_EOI_EN = 1'b1,
  parameter int IDX_W        = 3,
  parameter int ADDR_W       = 16
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output pq_op_e            op,
  output logic [IDX_W-1:0]  idx,
  output logic              trig_store,
  output logic              load_ok
);
  localparam bit TWO_PAGE = (SHIFT == 13) || (SHIFT == 17);
  localparam int MGMT_W   = TWO_PAGE ? SHIFT - 1 : SHIFT;

  logic              in_range;
  logic              on_mgmt;
  logic [MGMT_W-1:0] moff;

  assign idx      = req_addr[ADDR_W-1:SHIFT];
  assign in_range = int'(idx) < NUM_SRC;
  assign on_mgmt  = TWO_PAGE ? req_addr[SHIFT-1] : 1'b1;
  assign moff     = req_addr[MGMT_W-1:0];

  always_comb begin
    op         = OP_NONE;
    trig_store = 1'b0;
    load_ok    = 1'b0;
    if (req_valid && in_range) begin
      if (req_write) begin
        if (!on_mgmt) begin
          trig_store = 1'b1;
        end else if (STORE_EOI_EN && (moff == MGMT_W'(OFF_ST_EOI))) begin
          op = OP_EOI;
        end
      end else if (on_mgmt) begin
        load_ok = 1'b1;
        case (moff)
          MGMT_W'(OFF_LD_EOI): op = OP_EOI;
          MGMT_W'(OFF_GET):    op = OP_GET;
          MGMT_W'(OFF_SET00):  op = OP_SET00;
          MGMT_W'(OFF_SET01):  op = OP_SET01;
          MGMT_W'(OFF_SET10):  op = OP_SET10;
          MGMT_W'(OFF_SET11):  op = OP_SET11;
          default:             load_ok = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/pq_src_cell.sv
module pq_src_cell
  import pq_src_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  pq_op_e     op,
  input  logic       trig_store,
  input  logic       src_in,
  output logic [1:0] pq,
  output logic       asserted,
  output logic       notify
);
  logic       src_q;
  logic [1:0] pq_q;
  logic [1:0] pq_d;
  logic       trig;
  pq_op_e     op_eff;
  pq_step_t   nxt;

  assign op_eff = sel ? op : OP_NONE;
  assign trig   = (sel && trig_store) || (src_in && !src_q);

  always_comb begin
    nxt    = pq_step(pq_q, op_eff, IS_LEVEL && src_q, trig);
    pq_d   = nxt.pq;
    notify = nxt.notify;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq_q  <= PQ_IDLE;
      src_q <= 1'b0;
    end else begin
      pq_q  <= pq_d;
      src_q <= src_in;
    end
  end

  assign pq       = pq_q;
  assign asserted = IS_LEVEL ? src_q : 1'b0;

endmodule

// File: rtl/pq_notify_arb.sv
module pq_notify_arb #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic               ntf_ready,
  output logic               ntf_valid,
  output logic [IDX_W-1:0]   ntf_src
);
  logic [NUM_SRC-1:0] pend_q, pend_d, acc_mask;
  logic               lock_q, lock_d;
  logic [IDX_W-1:0]   lock_idx_q, lock_idx_d;
  logic [IDX_W-1:0]   lowest;

  always_comb begin
    lowest = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_q[i]) lowest = IDX_W'(i);
    end
  end

  assign ntf_valid = |pend_q;
  assign ntf_src   = lock_q ? lock_idx_q : lowest;

  always_comb begin
    acc_mask = '0;
    if (ntf_valid && ntf_ready) acc_mask[ntf_src] = 1'b1;
    pend_d     = (pend_q & ~acc_mask) | set_vec;
    lock_d     = ntf_valid && !ntf_ready;
    lock_idx_d = lock_idx_q;
    if (lock_d) lock_idx_d = ntf_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      pend_q     <= pend_d;
      lock_q     <= lock_d;
      lock_idx_q <= lock_idx_d;
    end
  end

endmodule

// File: rtl/pq_src_ctrl.sv
module pq_src_ctrl
  import pq_src_pkg::*;
#(
  parameter int               NUM_SRC      = 8,
  parameter int               SHIFT        = 13,
  parameter bit               STORE_EOI_EN = 1'b1,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int              IDX_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int              ADDR_W       = IDX_W + SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [7:0]         rsp_data,
  output logic               ntf_valid,
  output logic [IDX_W-1:0]   ntf_src,
  input  logic               ntf_ready
);
  pq_op_e                  op;
  logic [IDX_W-1:0]        idx;
  logic                    trig_store;
  logic                    load_ok;
  logic [NUM_SRC-1:0][1:0] pq_all;
  logic [NUM_SRC-1:0]      asserted_all;
  logic [NUM_SRC-1:0]      notify_all;
  logic                    rsp_valid_q, rsp_valid_d;
  logic [7:0]              rsp_data_q, rsp_data_d;
  logic                    rsp_en;

  pq_addr_decode #(
    .NUM_SRC(NUM_SRC), .SHIFT(SHIFT), .STORE_EOI_EN(STORE_EOI_EN),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .op(op), .idx(idx), .trig_store(trig_store), .load_ok(load_ok)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    pq_src_cell #(.IS_LEVEL(LEVEL_MASK[g])) u_cell (
      .clk(clk), .rst_n(rst_n),
      .sel(idx == IDX_W'(g)),
      .op(op), .trig_store(trig_store), .src_in(src_in[g]),
      .pq(pq_all[g]), .asserted(asserted_all[g]), .notify(notify_all[g])
    );
  end

  pq_notify_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .set_vec(notify_all),
    .ntf_ready(ntf_ready), .ntf_valid(ntf_valid), .ntf_src(ntf_src)
  );

  always_comb begin
    rsp_en      = req_valid && !req_write;
    rsp_valid_d = rsp_en;
    rsp_data_d  = 8'hFF;
    if (load_ok) rsp_data_d = {5'b0, asserted_all[idx], pq_all[idx]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= 8'hFF;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (rsp_en) rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/pq_src_ctrl_chk.sv
module pq_src_ctrl_chk #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_in,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic [7:0]         rsp_data,
  input logic               ntf_valid,
  input logic [IDX_W-1:0]   ntf_src,
  input logic               ntf_ready
);

  assert_ntf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid && !ntf_ready |=> ntf_valid && $stable(ntf_src));

  assert_ntf_src_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> int'(ntf_src) < NUM_SRC);

  assert_load_answered_R13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rsp_valid);

  assert_store_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> !rsp_valid);

  assert_rsp_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data == 8'hFF) || (rsp_data[7:3] == 5'd0));

endmodule

bind pq_src_ctrl pq_src_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/pq_src_ctrl_test.sv
`timescale 1ns/1ps
module pq_src_ctrl_test;
  localparam int NS = 8;
  localparam int SH = 13;
  localparam logic [7:0] LVL = 8'hF0;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_in;
  logic          req_valid, req_write, ntf_ready;
  logic [AW-1:0] req_addr;
  logic          rsp_valid, ntf_valid;
  logic [7:0]    rsp_data;
  logic [2:0]    ntf_src;

  int checks = 0;
  int errors = 0;

  logic [1:0]    m_pq [NS];
  logic [NS-1:0] m_srcq, m_pend;
  bit            m_lock;
  int            m_lock_i;

  pq_src_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .ntf_valid(ntf_valid), .ntf_src(ntf_src),
    .ntf_ready(ntf_ready)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [AW-1:0] mk(input int s, input bit mg, input int off);
    return AW'((s << SH) | (mg ? (1 << (SH - 1)) : 0) | off);
  endfunction

  // code: 0 none, 1 get, 2 eoi, 3..6 force 00..11
  function automatic int op_code(input bit w, input logic [AW-1:0] a, output bit tstore,
                                 output bit ok);
    bit mg;
    int off;
    mg = a[SH-1];
    off = int'(a[11:0]);
    tstore = 0;
    ok = 0;
    if (w) begin
      if (!mg) tstore = 1;
      return (mg && off == 'h400) ? 2 : 0;
    end
    if (!mg) return 0;
    ok = 1;
    if (off == 'h000) return 2;
    if (off == 'h800) return 1;
    if (off == 'hC00) return 3;
    if (off == 'hD00) return 4;
    if (off == 'hE00) return 5;
    if (off == 'hF00) return 6;
    ok = 0;
    return 0;
  endfunction

  function automatic int lowest(input logic [NS-1:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic step(input bit v, input bit w, input logic [AW-1:0] a,
                      input logic [NS-1:0] sin, input bit rdy, input string tag);
    int code, idx, shown;
    bit tstore, ok, vis, trig, ntf;
    logic [1:0] s;
    logic [7:0] exp_d;
    logic [NS-1:0] setv, acc;
    @(negedge clk);
    vis = |m_pend;
    shown = m_lock ? m_lock_i : lowest(m_pend);
    chk(ntf_valid == vis, "R14 ntf_valid", ntf_valid, vis);
    if (vis) chk(int'(ntf_src) == shown, "R14 ntf_src", ntf_src, shown);
    req_valid = v; req_write = w; req_addr = a; src_in = sin; ntf_ready = rdy;
    idx = int'(a[AW-1:SH]);
    code = v ? op_code(w, a, tstore, ok) : 0;
    if (!v) begin tstore = 0; ok = 0; end
    exp_d = ok ? {5'b0, LVL[idx] & m_srcq[idx], m_pq[idx]} : 8'hFF;
    setv = '0;
    for (int i = 0; i < NS; i++) begin
      s = m_pq[i];
      ntf = 0;
      if (i == idx && code == 2) begin
        if (s == 2'b11 || s == 2'b01 || (LVL[i] && m_srcq[i])) begin s = 2'b10; ntf = 1; end
        else s = 2'b00;
      end else if (i == idx && code >= 3) begin
        s = 2'(code - 3);
      end
      trig = (i == idx && tstore) || (sin[i] && !m_srcq[i]);
      if (trig) begin
        if (s == 2'b00) begin s = 2'b10; ntf = 1; end
        else if (s == 2'b10) s = 2'b11;
      end
      m_pq[i] = s;
      setv[i] = ntf;
    end
    acc = (vis && rdy) ? NS'(1) << shown : '0;
    m_lock = vis && !rdy;
    m_lock_i = shown;
    m_pend = (m_pend & ~acc) | setv;
    m_srcq = sin;
    @(posedge clk);
    #1;
    if (v && !w) begin
      chk(rsp_valid == 1'b1, "R13 rsp_valid", rsp_valid, 1);
      chk(rsp_data == exp_d, tag, rsp_data, exp_d);
    end else begin
      chk(rsp_valid == 1'b0, "R13 no rsp", rsp_valid, 0);
    end
  endtask

  task automatic ld(input int s, input bit mg, input int off, input string tag);
    step(1, 0, mk(s, mg, off), src_in, 0, tag);
  endtask
  task automatic st(input int s, input bit mg, input int off, input string tag);
    step(1, 1, mk(s, mg, off), src_in, 0, tag);
  endtask
  task automatic pins(input logic [NS-1:0] sin, input string tag);
    step(0, 0, '0, sin, 0, tag);
  endtask
  task automatic drain();
    for (int k = 0; k < 12; k++) step(0, 0, '0, src_in, 1, "R3 drain");
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 0; src_in = '0; req_valid = 0; req_write = 0; req_addr = '0; ntf_ready = 0;
    for (int i = 0; i < NS; i++) m_pq[i] = 2'b00;
    m_srcq = '0; m_pend = '0; m_lock = 0; m_lock_i = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(ntf_valid == 0, "R1 ntf_valid after reset", ntf_valid, 0);
    chk(rsp_valid == 0, "R1 rsp_valid after reset", rsp_valid, 0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < NS; i++) ld(i, 1, 'h800, "R1 state idle");

    st(2, 0, 'h10, "R9 trigger page store");
    ld(2, 1, 'h800, "R2 pending after trigger");
    st(2, 0, 'h0, "R4 coalesce");
    ld(2, 1, 'h800, "R4 queued");
    ld(2, 1, 'h000, "R5 eoi with Q");
    ld(2, 1, 'h800, "R5 back to pending");
    drain();
    ld(2, 1, 'h000, "R5 eoi no Q");
    ld(2, 1, 'h800, "R5 idle after eoi");

    ld(1, 1, 'hD00, "R7 force off");
    st(1, 0, 'h0, "R4 off ignores trigger");
    ld(1, 1, 'h800, "R4 still off");
    ld(3, 1, 'hF00, "R7 force 11");
    ld(3, 1, 'hE00, "R7 force 10");
    ld(3, 1, 'hC00, "R7 force 00");
    ld(3, 1, 'h800, "R7 idle");

    st(2, 0, 'h0, "R9 trigger");
    ld(2, 1, 'hF00, "R7 set 11");
    st(2, 1, 'h400, "R8 store eoi");
    ld(2, 1, 'h800, "R8 pending after store eoi");
    drain();

    pins(8'h01, "R10 edge rise");
    pins(8'h01, "R10 held high");
    ld(0, 1, 'h800, "R10 pending once");
    pins(8'h21, "R11 level rise");
    ld(5, 1, 'h800, "R11 asserted and pending");
    drain();
    ld(5, 1, 'h000, "R11 eoi while high");
    ld(5, 1, 'h800, "R11 retriggered");
    drain();
    pins(8'h01, "R11 level drop");
    ld(5, 1, 'h000, "R11 eoi while low");
    ld(5, 1, 'h800, "R11 idle");

    ld(4, 1, 'h100, "R12 undefined load");
    ld(4, 0, 'h800, "R12 trigger page load");
    st(4, 1, 'hC00, "R12 store undefined");
    ld(4, 1, 'h800, "R12 unchanged");

    ld(0, 1, 'hC00, "R7 clear 0");
    pins(8'h00, "R14 prep");
    pins(8'h42, "R14 two at once");
    pins(8'h42, "R14 hold");
    st(0, 0, 'h0, "R14 lower added while locked");
    pins(8'h42, "R14 hold");
    drain();

    for (int n = 0; n < 3000; n++) begin
      int k, s;
      logic [NS-1:0] sin;
      k = $urandom % 10;
      s = $urandom % NS;
      sin = src_in;
      if ($urandom % 6 == 0) sin[$urandom % NS] = ~sin[$urandom % NS];
      case (k)
        0: step(1, 0, mk(s, 1, 'h800), sin, 1'($urandom), "R6 random get");
        1: step(1, 0, mk(s, 1, 'h000), sin, 1'($urandom), "R5 random eoi");
        2, 3: step(1, 0, mk(s, 1, 'hC00 + ('h100 * ($urandom % 4))), sin, 1'($urandom), "R7 random set");
        4: step(1, 1, mk(s, 1, 'h400), sin, 1'($urandom), "R8 random store eoi");
        5, 6: step(1, 1, mk(s, 0, 'h8), sin, 1'($urandom), "R9 random trigger");
        7: step(1, 0, mk(s, $urandom % 2 == 0, 'h100), sin, 1'($urandom), "R12 random undefined");
        default: step(0, 0, '0, sin, 1'($urandom), "R10 random idle");
      endcase
    end
    drain();
    finish_run();
  end

endmodule